// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block counts retired instructions for a processor's debug logic and stops execution after a programmed number of them. Software loads a signed value into a 32-bit counter, which counts upward, and loads a nonzero threshold into a small level register. Each retiring instruction advances the counter by one, but only while the processor's current interrupt level is strictly below that threshold. Instructions retired at or above the threshold leave the counter alone. This keeps the debug handler and high-priority interrupts out of the count.

A counted instruction that retires while the counter already holds all-ones is the trigger point. In that same cycle the block tells the pipeline to drop that instruction and not complete it. One cycle later it raises a one-cycle debug request, reports the instruction's PC and gives cause code 0x1. Loading the counter with -N therefore traps on the instruction that would carry the counter from -1 to 0. A level threshold of zero switches counting and triggering off.

The reset input is asynchronous when it asserts. Its release passes through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `icnt_trigger_top`

## Requirements
- R1: While reset is applied, the counter, level register, debug request, reported PC, cause and kill output all read zero.
- R2: A retire with `retire_vld`=1 and `cur_lvl` unsigned-less-than the level register counts. If the counter is not all-ones, a counted retire adds one to the counter at the next clock edge.
- R3: A retire with `cur_lvl` greater than or equal to the level register leaves the counter unchanged. It asserts neither `retire_kill` nor `dbg_req`, even when the counter is all-ones.
- R4: While the level register holds 0, no retire changes the counter and none triggers, whatever `cur_lvl` is.
- R5: A counted retire while the counter is all-ones drives `retire_kill` high combinationally in that cycle. If no write happens in the same cycle, the counter keeps the all-ones value.
- R6: The cycle after a triggering retire, `dbg_req` is high for one cycle. From then on `dbg_pc` holds that retire's `retire_pc` until the next trigger. Triggering retires in back-to-back cycles give back-to-back requests, each carrying its own PC.
- R7: `dbg_cause` reads 4'h1 while `dbg_req` is high and 4'h0 otherwise.
- R8: `wr_cnt_en`=1 loads `wr_data` into the counter at the next edge. This write takes priority over an increment or a trigger in the same cycle, and the trigger still fires from the old value.
- R9: `wr_lvl_en`=1 loads the low 4 bits of `wr_data` into the level register. `lvl_q` reads the register back.
- R10: With the counter at 32'hFFFF_FFFE and the level at 1, a first retire at level 0 leaves the counter at all-ones with no trigger. A second such retire triggers and reports the second retire's PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released synchronously inside the block |
| retire_vld | input | 1 | An instruction retires this cycle |
| cur_lvl | input | 4 | Current interrupt level of the retiring instruction |
| retire_pc | input | 32 | PC of the retiring instruction |
| wr_cnt_en | input | 1 | Write strobe for the counter |
| wr_lvl_en | input | 1 | Write strobe for the level register |
| wr_data | input | 32 | Register write data |
| cnt_q | output | 32 | Counter read-back |
| lvl_q | output | 4 | Level register read-back |
| retire_kill | output | 1 | The retiring instruction must not complete (same cycle) |
| dbg_req | output | 1 | One-cycle debug request |
| dbg_pc | output | 32 | PC of the last triggering instruction |
| dbg_cause | output | 4 | Cause code, 0x1 during a request |

## Verification
The bench drives retires with `cur_lvl` below, equal to and above the threshold. This separates a strict comparison from an inclusive one, and a signed comparison from an unsigned one. It loads the counter with -2, plain small values, and the all-ones value, so a trigger on the -1 to 0 carry can be told apart from a trigger on an elapsed count or on reaching zero. It also drives a counter write in the same cycle as an increment and as a trigger, and triggering retires in back-to-back cycles. These cases show the write priority and show that the PC and pulse are captured per instruction rather than latched once.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
  localparam int unsigned CAUSE_W    = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_ICOUNT = 4'h1;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE   = 4'h0;
endpackage

// File: rtl/icnt_rst_sync.sv
module icnt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/icnt_regs.sv
module icnt_regs #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic             wr_cnt_en,
  input  logic             wr_lvl_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [LVL_W-1:0] lvl_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_d;
  logic [LVL_W-1:0] lvl_d;
  logic             cnt_ce;
  logic             lvl_ce;

  // counter: software write wins over the increment
  always_comb begin
    cnt_ce = wr_cnt_en | inc_en;
    if (wr_cnt_en) cnt_d = wr_data;
    else           cnt_d = cnt_q + ONE;
  end

  always_comb begin
    lvl_ce = wr_lvl_en;
    lvl_d  = wr_data[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_ce) lvl_q <= lvl_d;
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !wr_cnt_en) |=> (cnt_q == $past(cnt_q) + ONE));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !wr_cnt_en) |=> $stable(cnt_q));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_en |=> (cnt_q == $past(wr_data)));

  p_level_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lvl_en |=> (lvl_q == $past(wr_data[LVL_W-1:0])));
endmodule

// File: rtl/icnt_gate.sv
module icnt_gate #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned LVL_W = 4
) (
  input  logic             retire_vld,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic [LVL_W-1:0] lvl_q,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             inc_en,
  output logic             fire
);
  logic counted;
  logic at_top;

  always_comb begin
    counted = retire_vld && (cur_lvl < lvl_q);
    at_top  = &cnt_q;
    fire    = counted && at_top;
    inc_en  = counted && !at_top;
  end

  always_comb begin
    if (lvl_q == '0) p_off_when_zero_r4: assert (!inc_en && !fire);
  end
endmodule

// File: rtl/icnt_fire.sv
module icnt_fire
  import icnt_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [PC_W-1:0]    retire_pc,
  output logic               dbg_req,
  output logic [PC_W-1:0]    dbg_pc,
  output logic [CAUSE_W-1:0] dbg_cause
);
  logic            req_d;
  logic [PC_W-1:0] pc_d;
  logic            pc_ce;

  always_comb begin
    req_d = fire;
    pc_ce = fire;
    pc_d  = retire_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_req <= 1'b0;
    else        dbg_req <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dbg_pc <= '0;
    else if (pc_ce) dbg_pc <= pc_d;
  end

  assign dbg_cause = dbg_req ? CAUSE_ICOUNT : CAUSE_NONE;

  p_req_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (dbg_req && dbg_pc == $past(retire_pc)));

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (!dbg_req && $stable(dbg_pc)));
endmodule

// File: rtl/icnt_trigger_top.sv
module icnt_trigger_top
  import icnt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned LVL_W = 4,
  parameter int unsigned PC_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retire_vld,
  input  logic [LVL_W-1:0]   cur_lvl,
  input  logic [PC_W-1:0]    retire_pc,
  input  logic               wr_cnt_en,
  input  logic               wr_lvl_en,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [LVL_W-1:0]   lvl_q,
  output logic               retire_kill,
  output logic               dbg_req,
  output logic [PC_W-1:0]    dbg_pc,
  output logic [CAUSE_W-1:0] dbg_cause
);
  logic rst_int_n;
  logic inc_en;
  logic fire;

  icnt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  icnt_regs #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .inc_en    (inc_en),
    .wr_cnt_en (wr_cnt_en),
    .wr_lvl_en (wr_lvl_en),
    .wr_data   (wr_data),
    .cnt_q     (cnt_q),
    .lvl_q     (lvl_q)
  );

  icnt_gate #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_gate (
    .retire_vld (retire_vld),
    .cur_lvl    (cur_lvl),
    .lvl_q      (lvl_q),
    .cnt_q      (cnt_q),
    .inc_en     (inc_en),
    .fire       (fire)
  );

  icnt_fire #(.PC_W(PC_W)) u_fire (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fire      (fire),
    .retire_pc (retire_pc),
    .dbg_req   (dbg_req),
    .dbg_pc    (dbg_pc),
    .dbg_cause (dbg_cause)
  );

  assign retire_kill = fire;

  p_no_inc_on_fire_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (retire_kill && !wr_cnt_en) |=> (&cnt_q));

  p_blocked_level_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (retire_vld && cur_lvl >= lvl_q && !wr_cnt_en) |=> ($stable(cnt_q) && !dbg_req));
endmodule

// File: tb/icnt_trigger_top_test.sv
module icnt_trigger_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire_vld;
  logic [3:0]  cur_lvl;
  logic [31:0] retire_pc;
  logic        wr_cnt_en;
  logic        wr_lvl_en;
  logic [31:0] wr_data;
  logic [31:0] cnt_q;
  logic [3:0]  lvl_q;
  logic        retire_kill;
  logic        dbg_req;
  logic [31:0] dbg_pc;
  logic [3:0]  dbg_cause;

  int checks = 0;
  int fails  = 0;
  logic kill_s;
  bit done = 1'b0;

  always #5 clk = ~clk;

  icnt_trigger_top uut (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .cur_lvl(cur_lvl),
    .retire_pc(retire_pc), .wr_cnt_en(wr_cnt_en), .wr_lvl_en(wr_lvl_en),
    .wr_data(wr_data), .cnt_q(cnt_q), .lvl_q(lvl_q), .retire_kill(retire_kill),
    .dbg_req(dbg_req), .dbg_pc(dbg_pc), .dbg_cause(dbg_cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive after negedge, sample kill, pass the edge, return at next negedge
  task automatic cyc(input logic v, input logic [3:0] l, input logic [31:0] pc,
                     input logic wc, input logic wl, input logic [31:0] d);
    retire_vld = v; cur_lvl = l; retire_pc = pc;
    wr_cnt_en = wc; wr_lvl_en = wl; wr_data = d;
    #1 kill_s = retire_kill;
    @(negedge clk);
    retire_vld = 1'b0; wr_cnt_en = 1'b0; wr_lvl_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_regs(input logic [31:0] c, input logic [3:0] l);
    cyc(1'b0, 4'd0, 32'd0, 1'b1, 1'b0, c);
    cyc(1'b0, 4'd0, 32'd0, 1'b0, 1'b1, {28'd0, l});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; retire_vld = 1'b0; cur_lvl = '0; retire_pc = '0;
    wr_cnt_en = 1'b0; wr_lvl_en = 1'b0; wr_data = '0;
    repeat (2) @(negedge clk);
    chk("R1 cnt", cnt_q, 32'd0);
    chk("R1 lvl", {28'd0, lvl_q}, 32'd0);
    chk("R1 req", {31'd0, dbg_req}, 32'd0);
    chk("R1 pc", dbg_pc, 32'd0);
    chk("R1 cause", {28'd0, dbg_cause}, 32'd0);
    chk("R1 kill", {31'd0, retire_kill}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_level_write;
    cyc(1'b0, 4'd0, 32'd0, 1'b0, 1'b1, 32'hABCD_EF35);
    chk("R9 level low bits", {28'd0, lvl_q}, 32'd5);
  endtask

  task automatic t_count_and_block;
    set_regs(32'd5, 4'd3);
    cyc(1'b1, 4'd3, 32'h100, 1'b0, 1'b0, 0);
    chk("R3 equal level holds", cnt_q, 32'd5);
    cyc(1'b1, 4'd9, 32'h104, 1'b0, 1'b0, 0);
    chk("R3 high level holds", cnt_q, 32'd5);
    cyc(1'b1, 4'd2, 32'h108, 1'b0, 1'b0, 0);
    chk("R2 below level counts", cnt_q, 32'd6);
    cyc(1'b1, 4'd0, 32'h10C, 1'b0, 1'b0, 0);
    chk("R2 second count", cnt_q, 32'd7);
    cyc(1'b0, 4'd0, 32'h110, 1'b0, 1'b0, 0);
    chk("R2 no retire holds", cnt_q, 32'd7);
    set_regs(32'hFFFF_FFFF, 4'd3);
    cyc(1'b1, 4'd3, 32'h200, 1'b0, 1'b0, 0);
    chk("R3 no kill at level", {31'd0, kill_s}, 32'd0);
    chk("R3 no req at level", {31'd0, dbg_req}, 32'd0);
    chk("R3 cnt held", cnt_q, 32'hFFFF_FFFF);
  endtask

  task automatic t_level_zero;
    set_regs(32'hFFFF_FFFF, 4'd0);
    cyc(1'b1, 4'd0, 32'h300, 1'b0, 1'b0, 0);
    chk("R4 no kill", {31'd0, kill_s}, 32'd0);
    chk("R4 no req", {31'd0, dbg_req}, 32'd0);
    chk("R4 cnt held", cnt_q, 32'hFFFF_FFFF);
    set_regs(32'd40, 4'd0);
    cyc(1'b1, 4'd0, 32'h304, 1'b0, 1'b0, 0);
    chk("R4 no count", cnt_q, 32'd40);
  endtask

  task automatic t_fire_sequence;
    set_regs(32'hFFFF_FFFE, 4'd1);
    cyc(1'b1, 4'd0, 32'h4000_0010, 1'b0, 1'b0, 0);
    chk("R10 first step", cnt_q, 32'hFFFF_FFFF);
    chk("R10 no early kill", {31'd0, kill_s}, 32'd0);
    chk("R10 no early req", {31'd0, dbg_req}, 32'd0);
    cyc(1'b1, 4'd0, 32'h4000_0014, 1'b0, 1'b0, 0);
    chk("R5 kill same cycle", {31'd0, kill_s}, 32'd1);
    chk("R5 cnt not incremented", cnt_q, 32'hFFFF_FFFF);
    chk("R6 req pulse", {31'd0, dbg_req}, 32'd1);
    chk("R10 trigger pc", dbg_pc, 32'h4000_0014);
    chk("R7 cause", {28'd0, dbg_cause}, 32'h1);
    cyc(1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 0);
    chk("R6 req drops", {31'd0, dbg_req}, 32'd0);
    chk("R6 pc held", dbg_pc, 32'h4000_0014);
    chk("R7 cause idle", {28'd0, dbg_cause}, 32'h0);
  endtask

  task automatic t_back_to_back;
    set_regs(32'hFFFF_FFFF, 4'd2);
    cyc(1'b1, 4'd1, 32'h500, 1'b0, 1'b0, 0);
    chk("R6 first req", {31'd0, dbg_req}, 32'd1);
    chk("R6 first pc", dbg_pc, 32'h500);
    cyc(1'b1, 4'd0, 32'h504, 1'b0, 1'b0, 0);
    chk("R6 second req", {31'd0, dbg_req}, 32'd1);
    chk("R6 second pc", dbg_pc, 32'h504);
  endtask

  task automatic t_write_priority;
    set_regs(32'd10, 4'd1);
    cyc(1'b1, 4'd0, 32'h600, 1'b1, 1'b0, 32'd100);
    chk("R8 write over increment", cnt_q, 32'd100);
    set_regs(32'hFFFF_FFFF, 4'd1);
    cyc(1'b1, 4'd0, 32'h604, 1'b1, 1'b0, 32'd7);
    chk("R8 trigger from old value", {31'd0, kill_s}, 32'd1);
    chk("R8 write over trigger", cnt_q, 32'd7);
    chk("R8 req still raised", {31'd0, dbg_req}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_level_write();
    t_count_and_block();
    t_level_zero();
    t_fire_sequence();
    t_back_to_back();
    t_write_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule